// File: doc/BRIEF.md
# Six-Stage Data-Stationary Processor Pipeline

This block is a small in-order processor core with six stages: fetch, decode, register read, execute, memory and write-back. No central controller drives it. Each instruction's opcode moves down the pipeline together with its operands. Every stage has its own small decoder that works out that stage's controls from the opcode it holds and from any datapath status it receives. One example of such status is the completion flag of the multi-cycle multiplier.

The instruction set is deliberately tiny, and every instruction word is 32 bits wide:

- An add-immediate.
- An increment, which is the same addition with its two register specifiers merged and its immediate fixed at one.
- A packed instruction that increments two registers at once.
- A word load and a word store.
- A multiply that runs for several cycles and stalls the pipeline while it works.
- A jump with one delay slot that always executes.
- A halt.

The instruction and data memories are synchronous arrays inside the top module. A loading port fills the instruction memory while reset is held. A read port exposes the register file, so the final state of a run can be compared with expected values. The core does not forward results. A program must therefore place at least three other instructions between an instruction that writes a register and a later one that reads it.

Top module: `ds_core`

## Requirements
- R1: While reset is held and right after it, `done` and `stalled` are low and all eight registers read zero.
- R2: Opcode 1 (bits 31:28) writes R[27:25] <= R[24:22] + sign-extended bits 15:0.
- R3: Opcode 2 increments R[27:25] by one. Bits 24:0 are ignored, so no other register changes.
- R4: Opcode 3 increments both R[27:25] and R[24:22] by one in the same instruction. If both fields name the same register, that register rises by exactly one.
- R5: Opcode 5 stores R[27:25] to data word (R[24:22] + sign-extended bits 15:0) modulo the data depth. Opcode 4 loads that data word into R[27:25].
- R6: Opcode 6 jumps to the instruction address held in its low bits. Exactly one following instruction (the delay slot) executes before the target.
- R7: Opcode 7 writes the low 32 bits of R[24:22] * R[21:19] into R[27:25]. `stalled` stays high for MUL_LAT-1 cycles per multiply.
- R8: During a stall, fetch through execute hold their contents, and a bubble enters the memory stage. An instruction issued right after a multiply still completes correctly.
- R9: Opcode 15 (halt) stops fetch. No instruction after it changes any register. `done` rises once the halt reaches write-back and then stays high.
- R10: Opcode 0 and the unassigned opcodes 8 to 14 change no register.
- R11: A read issued four or more instructions after the write of the same register returns the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_we | input | 1 | Write strobe for the instruction memory |
| prog_addr | input | $clog2(IMEM_DEPTH) | Instruction memory word address |
| prog_data | input | 32 | Instruction word to store |
| dbg_sel | input | 3 | Register index to observe |
| dbg_val | output | 32 | Contents of the selected register |
| stalled | output | 1 | High while the multiplier holds the pipeline |
| done | output | 1 | High once a halt has reached write-back |

## Verification
The bench uses the default parameters: a 64-word program memory, a 32-word data memory and a three-cycle multiplier. With these values the exact two-cycle stall can be counted. An instruction placed directly behind a multiply shows whether the held stages and the inserted bubble lose or duplicate work. Because the data memory has 32 words, an offset of 35 lands on word 3, which exercises address wrap-around. The 64-word program space gives room for a jump that skips several instructions.

// File: rtl/ds_pkg.sv
package ds_pkg;
  localparam int XW   = 32;
  localparam int RAW  = 3;
  localparam int NREG = 8;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_ADDI = 4'd1,
    OP_INC  = 4'd2,
    OP_INC2 = 4'd3,
    OP_LD   = 4'd4,
    OP_ST   = 4'd5,
    OP_JMP  = 4'd6,
    OP_MUL  = 4'd7,
    OP_HALT = 4'd15
  } op_e;

  // register-read stage contents
  typedef struct packed {
    logic           vld;
    op_e            op;
    logic [RAW-1:0] d0;
    logic [RAW-1:0] d1;
    logic [RAW-1:0] sa;
    logic [RAW-1:0] sb;
    logic [XW-1:0]  imm;
  } rr_t;

  // execute stage contents
  typedef struct packed {
    logic           vld;
    op_e            op;
    logic [RAW-1:0] d0;
    logic [RAW-1:0] d1;
    logic [XW-1:0]  a;
    logic [XW-1:0]  b;
    logic [XW-1:0]  imm;
  } al_t;

  // memory stage contents
  typedef struct packed {
    logic           vld;
    op_e            op;
    logic [RAW-1:0] d0;
    logic [RAW-1:0] d1;
    logic [XW-1:0]  r0;
    logic [XW-1:0]  r1;
    logic [XW-1:0]  sd;
  } me_t;

  // write-back stage contents
  typedef struct packed {
    logic           vld;
    op_e            op;
    logic [RAW-1:0] d0;
    logic [RAW-1:0] d1;
    logic [XW-1:0]  r0;
    logic [XW-1:0]  r1;
  } wb_t;

  function automatic op_e op_of(input logic [3:0] code);
    case (code)
      4'd1:    return OP_ADDI;
      4'd2:    return OP_INC;
      4'd3:    return OP_INC2;
      4'd4:    return OP_LD;
      4'd5:    return OP_ST;
      4'd6:    return OP_JMP;
      4'd7:    return OP_MUL;
      4'd15:   return OP_HALT;
      default: return OP_NOP;
    endcase
  endfunction

  function automatic logic [XW-1:0] sext16(input logic [15:0] v);
    return {{(XW-16){v[15]}}, v};
  endfunction

  // Decode-stage field extraction. The increment forms merge their
  // specifiers and force the immediate to one.
  function automatic rr_t id_decode(input logic [31:0] w);
    rr_t t;
    t     = '0;
    t.op  = op_of(w[31:28]);
    t.d0  = w[27:25];
    t.d1  = w[24:22];
    t.sa  = w[24:22];
    t.sb  = w[27:25];
    t.imm = sext16(w[15:0]);
    case (t.op)
      OP_INC: begin
        t.sa  = w[27:25];
        t.imm = XW'(1);
      end
      OP_INC2: begin
        t.sa  = w[27:25];
        t.sb  = w[24:22];
        t.imm = XW'(1);
      end
      OP_MUL:  t.sb = w[21:19];
      default: ;
    endcase
    return t;
  endfunction

  // Execute-stage adders: {second result, first result}
  function automatic logic [2*XW-1:0] alu_pair(input logic [XW-1:0] a,
                                               input logic [XW-1:0] b,
                                               input logic [XW-1:0] imm);
    return {b + imm, a + imm};
  endfunction

  function automatic logic [XW-1:0] mul_lo(input logic [XW-1:0] a,
                                           input logic [XW-1:0] b);
    return a * b;
  endfunction

  // Write-back stage decoders
  function automatic logic writes_p0(input op_e op);
    return (op == OP_ADDI) || (op == OP_INC) || (op == OP_INC2) ||
           (op == OP_LD)   || (op == OP_MUL);
  endfunction

  function automatic logic writes_p1(input op_e op);
    return op == OP_INC2;
  endfunction

  // Memory stage decoders
  function automatic logic is_store(input op_e op);
    return op == OP_ST;
  endfunction

  function automatic logic is_load(input op_e op);
    return op == OP_LD;
  endfunction
endpackage

// File: rtl/ds_sram.sv
module ds_sram #(
  parameter int DEPTH = 64,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ds_regfile.sv
module ds_regfile
  import ds_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [RAW-1:0] ra0,
  input  logic [RAW-1:0] ra1,
  output logic [XW-1:0]  rd0,
  output logic [XW-1:0]  rd1,
  input  logic           we0,
  input  logic [RAW-1:0] wa0,
  input  logic [XW-1:0]  wd0,
  input  logic           we1,
  input  logic [RAW-1:0] wa1,
  input  logic [XW-1:0]  wd1,
  input  logic [RAW-1:0] dsel,
  output logic [XW-1:0]  dval
);
  logic [XW-1:0] rf [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      if (we0) rf[wa0] <= wd0;
      if (we1) rf[wa1] <= wd1;
    end
  end

  assign rd0  = rf[ra0];
  assign rd1  = rf[ra1];
  assign dval = rf[dsel];
endmodule

// File: rtl/ds_mul_unit.sv
module ds_mul_unit
  import ds_pkg::*;
#(
  parameter int LAT = 3,
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [XW-1:0] a,
  input  logic [XW-1:0] b,
  output logic          fin,
  output logic [XW-1:0] prod
);
  logic [CW-1:0] cnt_q;

  assign fin  = start && (cnt_q == CW'(LAT - 1));
  assign prod = mul_lo(a, b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (start && !fin) cnt_q <= cnt_q + CW'(1);
    else                    cnt_q <= '0;
  end
endmodule

// File: rtl/ds_core.sv
module ds_core
  import ds_pkg::*;
#(
  parameter int IMEM_DEPTH = 64,
  parameter int DMEM_DEPTH = 32,
  parameter int MUL_LAT    = 3,
  localparam int IAW       = $clog2(IMEM_DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           prog_we,
  input  logic [IAW-1:0] prog_addr,
  input  logic [31:0]    prog_data,
  input  logic [2:0]     dbg_sel,
  output logic [31:0]    dbg_val,
  output logic           stalled,
  output logic           done
);
  localparam int DAW = $clog2(DMEM_DEPTH);

  // pipeline state
  logic [IAW-1:0] pc_q;
  logic           id_vld;
  logic [31:0]    id_word;
  logic           halted_q;
  logic           done_q;
  rr_t            rr_q;
  al_t            al_q;
  me_t            me_q;
  wb_t            wb_q;

  // named internal events
  rr_t            id_dec;
  logic           id_is_jmp;
  logic           id_is_halt;
  logic           halt_any;
  logic           stall_w;
  logic [IAW-1:0] jmp_tgt_w;
  logic           mul_start;
  logic           mul_fin;
  logic [XW-1:0]  mul_prod;
  logic           me_vld_w;
  logic           wb_we0_w;
  logic           wb_we1_w;
  logic [XW-1:0]  wb_wd0_w;
  logic [XW-1:0]  rf_a;
  logic [XW-1:0]  rf_b;
  logic [XW-1:0]  dm_q;
  logic [2*XW-1:0] alu_res;

  // ---------------- fetch / decode ----------------
  assign id_dec     = id_decode(id_word);
  assign id_is_jmp  = id_vld && (id_dec.op == OP_JMP);
  assign id_is_halt = id_vld && (id_dec.op == OP_HALT);
  assign halt_any   = halted_q || id_is_halt;
  assign jmp_tgt_w  = id_word[IAW-1:0];

  ds_sram #(.DEPTH(IMEM_DEPTH), .W(32)) u_imem (
    .clk   (clk),
    .we    (prog_we),
    .waddr (prog_addr),
    .wdata (prog_data),
    .re    (!stall_w),
    .raddr (pc_q),
    .rdata (id_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= '0;
      id_vld   <= 1'b0;
      halted_q <= 1'b0;
    end else begin
      if (id_is_halt) halted_q <= 1'b1;
      if (!stall_w) begin
        id_vld <= !halt_any;
        if (!halt_any) pc_q <= id_is_jmp ? jmp_tgt_w : pc_q + IAW'(1);
      end
    end
  end

  // ---------------- register read ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (!stall_w) begin
      rr_q     <= id_dec;
      rr_q.vld <= id_vld;
    end
  end

  ds_regfile u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .ra0   (rr_q.sa),
    .ra1   (rr_q.sb),
    .rd0   (rf_a),
    .rd1   (rf_b),
    .we0   (wb_we0_w),
    .wa0   (wb_q.d0),
    .wd0   (wb_wd0_w),
    .we1   (wb_we1_w),
    .wa1   (wb_q.d1),
    .wd1   (wb_q.r1),
    .dsel  (dbg_sel),
    .dval  (dbg_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_q <= '0;
    end else if (!stall_w) begin
      al_q.vld <= rr_q.vld;
      al_q.op  <= rr_q.op;
      al_q.d0  <= rr_q.d0;
      al_q.d1  <= rr_q.d1;
      al_q.a   <= rf_a;
      al_q.b   <= rf_b;
      al_q.imm <= rr_q.imm;
    end
  end

  // ---------------- execute ----------------
  assign mul_start = al_q.vld && (al_q.op == OP_MUL);
  assign stall_w   = mul_start && !mul_fin;
  assign alu_res   = alu_pair(al_q.a, al_q.b, al_q.imm);

  ds_mul_unit #(.LAT(MUL_LAT)) u_mul (
    .clk   (clk),
    .rst_n (rst_n),
    .start (mul_start),
    .a     (al_q.a),
    .b     (al_q.b),
    .fin   (mul_fin),
    .prod  (mul_prod)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      me_q <= '0;
    end else if (stall_w) begin
      me_q <= '0;
    end else begin
      me_q.vld <= al_q.vld;
      me_q.op  <= al_q.op;
      me_q.d0  <= al_q.d0;
      me_q.d1  <= al_q.d1;
      me_q.r0  <= (al_q.op == OP_MUL) ? mul_prod : alu_res[XW-1:0];
      me_q.r1  <= alu_res[2*XW-1:XW];
      me_q.sd  <= al_q.b;
    end
  end

  // ---------------- memory ----------------
  assign me_vld_w = me_q.vld;

  ds_sram #(.DEPTH(DMEM_DEPTH), .W(XW)) u_dmem (
    .clk   (clk),
    .we    (me_q.vld && is_store(me_q.op)),
    .waddr (me_q.r0[DAW-1:0]),
    .wdata (me_q.sd),
    .re    (1'b1),
    .raddr (me_q.r0[DAW-1:0]),
    .rdata (dm_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_q <= '0;
    end else begin
      wb_q.vld <= me_q.vld;
      wb_q.op  <= me_q.op;
      wb_q.d0  <= me_q.d0;
      wb_q.d1  <= me_q.d1;
      wb_q.r0  <= me_q.r0;
      wb_q.r1  <= me_q.r1;
    end
  end

  // ---------------- write-back ----------------
  assign wb_we0_w = wb_q.vld && writes_p0(wb_q.op);
  assign wb_we1_w = wb_q.vld && writes_p1(wb_q.op);
  assign wb_wd0_w = is_load(wb_q.op) ? dm_q : wb_q.r0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    done_q <= 1'b0;
    else if (wb_q.vld && (wb_q.op == OP_HALT))     done_q <= 1'b1;
  end

  assign stalled = stall_w;
  assign done    = done_q;
endmodule

// File: rtl/ds_core_chk.sv
module ds_core_chk #(
  parameter int MUL_LAT = 3,
  parameter int IAW     = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           stall,
  input logic           jump,
  input logic [IAW-1:0] jump_tgt,
  input logic [IAW-1:0] pc,
  input logic           me_vld,
  input logic           wb_we0,
  input logic           wb_we1,
  input logic           done
);
  int run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_q <= 0;
    else if (stall) run_q <= run_q + 1;
    else            run_q <= 0;
  end

  // R7
  stall_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (run_q < MUL_LAT - 1));

  // R8
  stall_hold_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(pc));

  // R8
  stall_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !me_vld);

  // R6
  jump_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jump && !stall) |=> (pc == $past(jump_tgt)));

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R9
  no_write_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!wb_we0 && !wb_we1));

  // R4
  second_port_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we1 |-> wb_we0);
endmodule

bind ds_core ds_core_chk #(.MUL_LAT(MUL_LAT), .IAW(IAW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .stall    (stall_w),
  .jump     (id_is_jmp),
  .jump_tgt (jmp_tgt_w),
  .pc       (pc_q),
  .me_vld   (me_vld_w),
  .wb_we0   (wb_we0_w),
  .wb_we1   (wb_we1_w),
  .done     (done_q)
);

// File: tb/ds_core_bench.sv
module ds_core_bench;
  localparam int IDEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_we = 1'b0;
  logic [5:0]  prog_addr = '0;
  logic [31:0] prog_data = '0;
  logic [2:0]  dbg_sel = '0;
  logic [31:0] dbg_val;
  logic        stalled;
  logic        done;

  always #5 clk = ~clk;

  ds_core u_ds_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_we   (prog_we),
    .prog_addr (prog_addr),
    .prog_data (prog_data),
    .dbg_sel   (dbg_sel),
    .dbg_val   (dbg_val),
    .stalled   (stalled),
    .done      (done)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int stall_cnt = 0;
  logic [31:0] prog [IDEPTH];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: run did not finish, act=%0d cycles exp<=150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] enc(input logic [3:0] op, input logic [2:0] fb,
                                      input logic [2:0] fa, input logic [2:0] fc,
                                      input logic [15:0] imm);
    return {op, fb, fa, fc, 3'b000, imm};
  endfunction

  typedef struct packed {
    logic [15:0] a;
    logic [15:0] b;
    logic [31:0] ins;
    logic [2:0]  rg;
    logic [31:0] exp;
    logic [3:0]  req;
  } row_t;

  // r1 <- a and r2 <- b first, three spacers (R11 spacing), then ins, then halt
  localparam row_t ROWS [11] = '{
    '{16'd10, 16'd0,  enc(4'd1, 3'd3, 3'd1, 3'd0, 16'd5),      3'd3, 32'd15,         4'd2},  // R2
    '{16'd0,  16'd2,  enc(4'd1, 3'd4, 3'd2, 3'd0, 16'hFFFD),   3'd4, 32'hFFFF_FFFF,  4'd2},  // R2
    '{16'd7,  16'd40, {4'd2, 3'd1, 25'h15A5A5A},               3'd1, 32'd8,          4'd3},  // R3
    '{16'd7,  16'd40, {4'd2, 3'd1, 25'h15A5A5A},               3'd2, 32'd40,         4'd3},  // R3
    '{16'd3,  16'd9,  enc(4'd3, 3'd1, 3'd2, 3'd0, 16'd0),      3'd1, 32'd4,          4'd4},  // R4
    '{16'd3,  16'd9,  enc(4'd3, 3'd1, 3'd2, 3'd0, 16'd0),      3'd2, 32'd10,         4'd4},  // R4
    '{16'd3,  16'd9,  enc(4'd3, 3'd1, 3'd1, 3'd0, 16'd0),      3'd1, 32'd4,          4'd4},  // R4
    '{16'd300, 16'd7, enc(4'd7, 3'd5, 3'd1, 3'd2, 16'd0),      3'd5, 32'd2100,       4'd7},  // R7
    '{16'h7FFF, 16'h7FFF, enc(4'd7, 3'd5, 3'd1, 3'd2, 16'd0),  3'd5, 32'h3FFF_0001,  4'd7},  // R7
    '{16'd11, 16'd0,  enc(4'd8, 3'd1, 3'd1, 3'd0, 16'd7),      3'd1, 32'd11,         4'd10}, // R10
    '{16'd11, 16'd0,  enc(4'd0, 3'd1, 3'd1, 3'd0, 16'd7),      3'd1, 32'd11,         4'd10}  // R10
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] v);
    dbg_sel = idx;
    #1;
    v = dbg_val;
  endtask

  task automatic clear_prog();
    for (int i = 0; i < IDEPTH; i++) prog[i] = 32'h0;
  endtask

  task automatic run();
    int n;
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < IDEPTH; i++) begin
      prog_we   = 1'b1;
      prog_addr = 6'(i);
      prog_data = prog[i];
      @(negedge clk);
    end
    prog_we   = 1'b0;
    rst_n     = 1'b1;
    stall_cnt = 0;
    n = 0;
    while (!done && n < 400) begin
      @(negedge clk);
      if (stalled) stall_cnt++;
      n++;
    end
    if (!done) begin
      errors++;
      $display("FAIL R9: done never rose, act=0 exp=1");
    end
  endtask

  initial begin
    logic [31:0] v;

    // table of single-instruction cases
    for (int k = 0; k < 11; k++) begin
      clear_prog();
      prog[0] = enc(4'd1, 3'd1, 3'd0, 3'd0, ROWS[k].a);
      prog[1] = enc(4'd1, 3'd2, 3'd0, 3'd0, ROWS[k].b);
      prog[5] = ROWS[k].ins;
      prog[6] = enc(4'd15, 3'd0, 3'd0, 3'd0, 16'd0);
      run();
      rd(ROWS[k].rg, v);
      chk($sformatf("R%0d row %0d", ROWS[k].req, k), v, ROWS[k].exp);
    end

    // R1: reset clears everything (registers were non-zero from the last row)
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 stalled", {31'd0, stalled}, 32'd0);
    for (int r = 0; r < 8; r++) begin
      rd(3'(r), v);
      chk($sformatf("R1 reg %0d", r), v, 32'd0);
    end

    // R6: delayed jump, the slot runs and the skipped words do not
    clear_prog();
    prog[0] = enc(4'd6, 3'd0, 3'd0, 3'd0, 16'd6);
    prog[1] = enc(4'd1, 3'd1, 3'd0, 3'd0, 16'd1);
    prog[2] = enc(4'd1, 3'd2, 3'd0, 3'd0, 16'd2);
    prog[3] = enc(4'd1, 3'd4, 3'd0, 3'd0, 16'd4);
    prog[4] = enc(4'd1, 3'd4, 3'd0, 3'd0, 16'd4);
    prog[5] = enc(4'd1, 3'd4, 3'd0, 3'd0, 16'd4);
    prog[6] = enc(4'd1, 3'd3, 3'd0, 3'd0, 16'd3);
    prog[7] = enc(4'd15, 3'd0, 3'd0, 3'd0, 16'd0);
    run();
    rd(3'd1, v); chk("R6 delay slot executed", v, 32'd1);
    rd(3'd2, v); chk("R6 skipped word", v, 32'd0);
    rd(3'd4, v); chk("R6 skipped words", v, 32'd0);
    rd(3'd3, v); chk("R6 target executed", v, 32'd3);

    // R5: store then load, including wrap of the data address
    clear_prog();
    prog[0]  = enc(4'd1, 3'd1, 3'd0, 3'd0, 16'd5);
    prog[1]  = enc(4'd1, 3'd2, 3'd0, 3'd0, 16'h0077);
    prog[5]  = enc(4'd5, 3'd2, 3'd1, 3'd0, 16'd2);
    prog[6]  = enc(4'd4, 3'd3, 3'd0, 3'd0, 16'd7);
    prog[7]  = enc(4'd5, 3'd1, 3'd0, 3'd0, 16'd35);
    prog[8]  = enc(4'd4, 3'd4, 3'd0, 3'd0, 16'd3);
    prog[9]  = enc(4'd15, 3'd0, 3'd0, 3'd0, 16'd0);
    run();
    rd(3'd3, v); chk("R5 load after store", v, 32'h77);
    rd(3'd4, v); chk("R5 wrapped address", v, 32'd5);

    // R7 / R8: multiply stall length and the instruction right behind it
    clear_prog();
    prog[0]  = enc(4'd1, 3'd1, 3'd0, 3'd0, 16'd6);
    prog[1]  = enc(4'd1, 3'd2, 3'd0, 3'd0, 16'd7);
    prog[5]  = enc(4'd7, 3'd5, 3'd1, 3'd2, 16'd0);
    prog[6]  = enc(4'd1, 3'd6, 3'd0, 3'd0, 16'd9);
    prog[10] = enc(4'd1, 3'd7, 3'd5, 3'd0, 16'd1);
    prog[11] = enc(4'd15, 3'd0, 3'd0, 3'd0, 16'd0);
    run();
    chk("R7 stall cycles", 32'(stall_cnt), 32'd2);
    rd(3'd5, v); chk("R7 product", v, 32'd42);
    rd(3'd6, v); chk("R8 follower completes", v, 32'd9);
    rd(3'd7, v); chk("R8 product reused", v, 32'd43);

    // R11: chained use four instructions apart
    clear_prog();
    prog[0] = enc(4'd1, 3'd1, 3'd0, 3'd0, 16'd9);
    prog[4] = enc(4'd2, 3'd1, 3'd0, 3'd0, 16'd0);
    prog[8] = enc(4'd1, 3'd2, 3'd1, 3'd0, 16'd100);
    prog[9] = enc(4'd15, 3'd0, 3'd0, 3'd0, 16'd0);
    run();
    rd(3'd2, v); chk("R11 chained value", v, 32'd110);

    // R9: halt stops everything behind it and done stays high
    clear_prog();
    prog[0] = enc(4'd1, 3'd1, 3'd0, 3'd0, 16'd1);
    prog[1] = enc(4'd15, 3'd0, 3'd0, 3'd0, 16'd0);
    prog[2] = enc(4'd1, 3'd2, 3'd0, 3'd0, 16'd5);
    prog[3] = enc(4'd1, 3'd3, 3'd0, 3'd0, 16'd6);
    run();
    rd(3'd1, v); chk("R9 before halt", v, 32'd1);
    repeat (10) @(negedge clk);
    chk("R9 done held", {31'd0, done}, 32'd1);
    rd(3'd2, v); chk("R9 after halt r2", v, 32'd0);
    rd(3'd3, v); chk("R9 after halt r3", v, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule